// File: doc/BRIEF.md
# Two-Level Fast/Normal Interrupt Controller

This block collects a set of level-sensitive interrupt source lines and turns them into two CPU request lines: a fast request and a normal request. Each source has its own enable bit for each class, and the block shows each class's pending set (source AND enable) in a read-only register. Fast requests always win. The two request lines are never high together. An autovector strobe goes with every request, so the CPU handles each interrupt as autovectored and software finds the cause by reading a pending register.

The three lowest source bits are tied high. Setting their enable bits therefore lets software raise an interrupt of either class. Registers sit on a simple 32-bit bus with a byte address, read and write strobes, an access size and a supervisor flag. A read returns data in the same cycle. A write takes effect at the next clock edge. A refused access raises an error response in the same cycle.

Top module: `irq_fn_ctrl`

## Requirements
- R1: A supervisor word read of offset 0x00 returns the source lines, with bits 0, 1 and 2 always read as one and bits at or above N_SRC read as zero.
- R2: Offset 0x04 holds the normal enable set and offset 0x08 holds the fast enable set, both read/write. Offset 0x0C reads the normal pending set (source AND normal enable) and offset 0x10 reads the fast pending set (source AND fast enable).
- R3: Any read or write made with sup_i low returns err_o=1 and rdata_o=0, and changes no state.
- R4: A write to offset 0x00, or a read of it with size other than word, returns err_o=1. Size codes are 0=byte, 1=halfword, 2=word, and code 3 is refused with err_o=1 at every offset.
- R5: A sub-word write to an enable register updates only the byte lanes it selects. A byte write selects lane addr_i[1:0]. A halfword write selects lanes 0-1 when addr_i[1]=0 and lanes 2-3 when addr_i[1]=1. Lane k takes wdata_i[8k+7:8k]. Lanes at or above N_SRC bits are ignored.
- R6: A write to either pending register returns err_o=0 and leaves the pending value unchanged.
- R7: Any access to an offset of 0x14 or above returns err_o=1.
- R8: fast_req_o equals the OR of the fast pending bits, one clock after the sources or enables change.
- R9: norm_req_o equals the OR of the normal pending bits when no fast pending bit is set, and is otherwise low in the same cycle that fast_req_o rises, so both lines are never high together.
- R10: avec_o is high exactly when fast_req_o or norm_req_o is high.
- R11: After reset both enable registers read zero and all three request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Level-sensitive interrupt sources |
| addr_i | input | 5 | Byte address of the register access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, lane-aligned |
| sup_i | input | 1 | High for a supervisor-mode access |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| err_o | output | 1 | Bus error response for the current access |
| fast_req_o | output | 1 | Fast interrupt request to the CPU |
| norm_req_o | output | 1 | Normal interrupt request to the CPU |
| avec_o | output | 1 | Autovector strobe |

## Verification
The bench builds the block with N_SRC=8, which makes the source space 256 values. Every source value is swept against a spread of normal and fast enable patterns, and the request lines and both pending reads are compared with values computed in the bench. With eight sources, byte lane 0 covers every enable bit while lanes 1 to 3 fall outside the register. This makes both the writes that land and the writes that must be dropped visible through readback.

// File: rtl/irq_fn_pkg.sv
package irq_fn_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_NEN  = 3'd1;
  localparam logic [2:0] REG_FEN  = 3'd2;
  localparam logic [2:0] REG_NPND = 3'd3;
  localparam logic [2:0] REG_FPND = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] lane_sel(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0:    lane_sel = 4'b0001 << a;
      2'd1:    lane_sel = a[1] ? 4'b1100 : 4'b0011;
      default: lane_sel = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/irq_fn_regfile.sv
module irq_fn_regfile
  import irq_fn_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sup_i,
  input  logic [N_SRC-1:0]  src_eff_i,
  input  logic [N_SRC-1:0]  npend_i,
  input  logic [N_SRC-1:0]  fpend_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic [N_SRC-1:0]  nen_o,
  output logic [N_SRC-1:0]  fen_o
);
  logic [2:0]       idx;
  logic             access;
  logic             err;
  logic [N_SRC-1:0] rdv;
  logic [DW-1:0]    wmask;
  logic [3:0]       lanes;
  logic [N_SRC-1:0] nen_q, fen_q, m;

  assign idx    = addr_i[4:2];
  assign access = rd_i | wr_i;
  assign lanes  = lane_sel(size_i, addr_i[1:0]);
  assign m      = wmask[N_SRC-1:0];

  always_comb begin
    for (int b = 0; b < 4; b++) wmask[b*8 +: 8] = {8{lanes[b]}};
  end

  always_comb begin
    err = 1'b0;
    rdv = '0;
    if (access) begin
      if (!sup_i || size_i == SZ_RSV || idx > REG_FPND) begin
        err = 1'b1;
      end else begin
        case (idx)
          REG_SRC: begin
            if (wr_i || size_i != SZ_WORD) err = 1'b1;
            else rdv = src_eff_i;
          end
          REG_NEN:  rdv = nen_q;
          REG_FEN:  rdv = fen_q;
          REG_NPND: rdv = npend_i;
          default:  rdv = fpend_i;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && !err) rdata_o[N_SRC-1:0] = rdv;
  end
  assign err_o = err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nen_q <= '0;
      fen_q <= '0;
    end else if (wr_i && !err) begin
      if (idx == REG_NEN) nen_q <= (nen_q & ~m) | (wdata_i[N_SRC-1:0] & m);
      if (idx == REG_FEN) fen_q <= (fen_q & ~m) | (wdata_i[N_SRC-1:0] & m);
    end
  end

  assign nen_o = nen_q;
  assign fen_o = fen_q;

  assert_user_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !sup_i) |-> (err_o && rdata_o == '0));
  assert_user_nochange_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !sup_i) |=> ($stable(nen_q) && $stable(fen_q)));
  assert_src_ro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == REG_SRC) |-> err_o);
  assert_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && idx > REG_FPND) |-> err_o);
  assert_src_sw_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !err_o && idx == REG_SRC) |-> (rdata_o[2:0] == 3'b111));
endmodule

// File: rtl/irq_fn_arb.sv
module irq_fn_arb #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] npend_i,
  input  logic [N_SRC-1:0] fpend_i,
  output logic             fast_req_o,
  output logic             norm_req_o,
  output logic             avec_o
);
  logic any_f, any_n;
  logic fast_q, norm_q, avec_q;

  assign any_f = |fpend_i;
  assign any_n = |npend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      norm_q <= 1'b0;
      avec_q <= 1'b0;
    end else begin
      fast_q <= any_f;
      norm_q <= any_n & ~any_f;  // fast preempts normal in the same edge
      avec_q <= any_f | any_n;
    end
  end

  assign fast_req_o = fast_q;
  assign norm_req_o = norm_q;
  assign avec_o     = avec_q;

  assert_fast_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_f |=> fast_req_o);
  assert_norm_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_n && !any_f) |=> norm_req_o);
  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fast_req_o && norm_req_o));
  assert_avec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o == (fast_req_o || norm_req_o));
endmodule

// File: rtl/irq_fn_ctrl.sv
module irq_fn_ctrl
  import irq_fn_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_SW  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sup_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              fast_req_o,
  output logic              norm_req_o,
  output logic              avec_o
);
  localparam logic [N_SRC-1:0] SW_MASK = N_SRC'((64'd1 << N_SW) - 64'd1);

  logic [N_SRC-1:0] src_eff, nen, fen, npend, fpend;

  assign src_eff = src_i | SW_MASK;
  assign npend   = src_eff & nen;
  assign fpend   = src_eff & fen;

  irq_fn_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .sup_i     (sup_i),
    .src_eff_i (src_eff),
    .npend_i   (npend),
    .fpend_i   (fpend),
    .rdata_o   (rdata_o),
    .err_o     (err_o),
    .nen_o     (nen),
    .fen_o     (fen)
  );

  irq_fn_arb #(.N_SRC(N_SRC)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .npend_i    (npend),
    .fpend_i    (fpend),
    .fast_req_o (fast_req_o),
    .norm_req_o (norm_req_o),
    .avec_o     (avec_o)
  );

  initial assert_param_R1: assert (N_SW <= N_SRC && N_SRC <= DW);
endmodule

// File: tb/irq_fn_ctrl_tb.sv
module irq_fn_ctrl_tb;
  localparam int unsigned NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [4:0]    addr = '0;
  logic          rd = 1'b0, wr = 1'b0, sup = 1'b0;
  logic [1:0]    size = 2'd2;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err, fast, norm, avec;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_fn_ctrl #(.N_SRC(NS), .N_SW(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .size_i(size), .wdata_i(wdata), .sup_i(sup), .rdata_o(rdata),
    .err_o(err), .fast_req_o(fast), .norm_req_o(norm), .avec_o(avec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic r, input logic w, input logic s, input logic [1:0] sz,
                     input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] rv, output logic ev);
    @(negedge clk);
    rd = r; wr = w; sup = s; size = sz; addr = a; wdata = d;
    #1;
    rv = rdata; ev = err;
    @(posedge clk);
    #1;
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic chk_out(string tag, logic [NS-1:0] s, logic [NS-1:0] ne, logic [NS-1:0] fe);
    logic [NS-1:0] se;
    logic ef, en;
    se = s | 8'h07;
    ef = |(se & fe);
    en = |(se & ne) && !ef;
    chk({tag, " fast"}, {31'b0, fast}, {31'b0, ef});
    chk({tag, " norm"}, {31'b0, norm}, {31'b0, en});
    chk({tag, " avec"}, {31'b0, avec}, {31'b0, ef | en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic ev;
    logic [7:0] nen_set [5];
    logic [7:0] fen_set [4];
    nen_set = '{8'h00, 8'h01, 8'h10, 8'hF0, 8'hFF};
    fen_set = '{8'h00, 8'h02, 8'h80, 8'h30};

    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 fast", {31'b0, fast}, 32'd0);
    chk("R11 norm", {31'b0, norm}, 32'd0);
    chk("R11 avec", {31'b0, avec}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev); chk("R11 nen", rv, 0);
    acc(1, 0, 1, 2, 5'h08, 0, rv, ev); chk("R11 fen", rv, 0);

    // R1 exhaustive source read
    for (int s = 0; s < 256; s++) begin
      src = 8'(s);
      acc(1, 0, 1, 2, 5'h00, 0, rv, ev);
      chk("R1 src", rv, {24'b0, 8'(s) | 8'h07});
      chk("R1 err", {31'b0, ev}, 0);
    end

    // R2 R8 R9 R10 sweep
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 4; j++) begin
        acc(0, 1, 1, 2, 5'h04, {24'b0, nen_set[i]}, rv, ev);
        acc(0, 1, 1, 2, 5'h08, {24'b0, fen_set[j]}, rv, ev);
        acc(1, 0, 1, 2, 5'h04, 0, rv, ev); chk("R2 nen rd", rv, {24'b0, nen_set[i]});
        acc(1, 0, 1, 2, 5'h08, 0, rv, ev); chk("R2 fen rd", rv, {24'b0, fen_set[j]});
        for (int s = 0; s < 256; s++) begin
          @(negedge clk) src = 8'(s);
          acc(1, 0, 1, 2, 5'h0C, 0, rv, ev);
          chk("R2 npend", rv, {24'b0, (8'(s) | 8'h07) & nen_set[i]});
          acc(1, 0, 1, 0, 5'h10, 0, rv, ev);
          chk("R2 fpend", rv, {24'b0, (8'(s) | 8'h07) & fen_set[j]});
          chk_out("R8 R9 R10", 8'(s), nen_set[i], fen_set[j]);
        end
      end
    end

    // R9 preemption: normal active, then fast appears
    acc(0, 1, 1, 2, 5'h08, 32'h0000_0040, rv, ev);
    acc(0, 1, 1, 2, 5'h04, 32'h0000_0001, rv, ev);
    @(negedge clk) src = 8'h00;
    @(negedge clk);
    chk("R9 norm before", {31'b0, norm}, 1);
    src = 8'h40;
    @(posedge clk); #1;
    chk("R9 fast rises", {31'b0, fast}, 1);
    chk("R9 norm drops", {31'b0, norm}, 0);
    chk("R10 avec held", {31'b0, avec}, 1);

    // R3 user mode
    acc(0, 1, 0, 2, 5'h04, 32'h0000_00AA, rv, ev); chk("R3 wr err", {31'b0, ev}, 1);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);             chk("R3 nen kept", rv, 32'h01);
    acc(0, 1, 0, 2, 5'h08, 32'h0000_0000, rv, ev); chk("R3 wr err fen", {31'b0, ev}, 1);
    acc(1, 0, 1, 2, 5'h08, 0, rv, ev);             chk("R3 fen kept", rv, 32'h40);
    acc(1, 0, 0, 2, 5'h00, 0, rv, ev);
    chk("R3 rd err", {31'b0, ev}, 1); chk("R3 rd data", rv, 0);

    // R4 source access rules and size 3
    acc(0, 1, 1, 2, 5'h00, 32'hFF, rv, ev); chk("R4 src wr", {31'b0, ev}, 1);
    acc(1, 0, 1, 0, 5'h00, 0, rv, ev);      chk("R4 src byte", {31'b0, ev}, 1);
    acc(1, 0, 1, 1, 5'h00, 0, rv, ev);      chk("R4 src half", {31'b0, ev}, 1);
    acc(1, 0, 1, 3, 5'h04, 0, rv, ev);      chk("R4 size3", {31'b0, ev}, 1);
    acc(0, 1, 1, 3, 5'h04, 32'hFF, rv, ev); chk("R4 size3 wr", {31'b0, ev}, 1);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);      chk("R4 nen kept", rv, 32'h01);

    // R5 byte lanes
    acc(0, 1, 1, 0, 5'h04, 32'h0000_00AA, rv, ev); chk("R5 b0 err", {31'b0, ev}, 0);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);             chk("R5 b0", rv, 32'hAA);
    acc(0, 1, 1, 0, 5'h05, 32'h0000_5533, rv, ev);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);             chk("R5 b1 only", rv, 32'hAA);
    acc(0, 1, 1, 1, 5'h06, 32'h0000_0011, rv, ev);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);             chk("R5 h1 only", rv, 32'hAA);
    acc(0, 1, 1, 1, 5'h04, 32'h0000_00C3, rv, ev);
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev);             chk("R5 h0", rv, 32'hC3);
    acc(0, 1, 1, 0, 5'h08, 32'h0000_0024, rv, ev);
    acc(1, 0, 1, 2, 5'h08, 0, rv, ev);             chk("R5 fen b0", rv, 32'h24);

    // R6 pending writes ignored
    @(negedge clk) src = 8'h30;
    acc(0, 1, 1, 2, 5'h0C, 32'h0, rv, ev); chk("R6 npend wr err", {31'b0, ev}, 0);
    acc(1, 0, 1, 2, 5'h0C, 0, rv, ev);     chk("R6 npend", rv, 32'h37 & 32'hC3);
    acc(0, 1, 1, 2, 5'h10, 32'hFF, rv, ev); chk("R6 fpend wr err", {31'b0, ev}, 0);
    acc(1, 0, 1, 2, 5'h10, 0, rv, ev);     chk("R6 fpend", rv, 32'h37 & 32'h24);

    // R7 out of range
    for (int a = 5'h14; a <= 5'h1C; a += 4) begin
      acc(1, 0, 1, 2, 5'(a), 0, rv, ev); chk("R7 rd", {31'b0, ev}, 1);
      acc(0, 1, 1, 2, 5'(a), 32'h0, rv, ev); chk("R7 wr", {31'b0, ev}, 1);
    end
    acc(1, 0, 1, 2, 5'h04, 0, rv, ev); chk("R7 nen kept", rv, 32'hC3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule